// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. A requester hands it a virtual address and the base of a first-level table. The block then reads page table entries over a simple word-read memory port, one read at a time. The result is either a physical address or a page-fault flag. Pages are 4 KB, so the low 12 bits of the address never go through translation. The 20-bit virtual page number is split into two 10-bit table indices. The upper index selects the first-level entry, and the lower index selects the second-level entry.

A 16-line direct-mapped translation cache sits in front of the walk. It is looked up with the virtual page number: the low 4 VPN bits select a line, and the upper 16 bits are the tag. On a hit the result comes back with no memory traffic. A walk that succeeds writes its result into the selected line. A walk that faults leaves the cache untouched. After software repairs the table, the same request can therefore be issued again and it will succeed. A flush input empties the cache.

Only one translation is in flight at a time. The result is reported with a one-cycle done pulse. The fault flag and the address are held steady between pulses.

Top module: `pagewalk_xlate`

## Requirements
- R1: On a successful translation, paddr[11:0] equals the request's vaddr[11:0].
- R2: The first read address is {root[31:12], vaddr[31:22], 2'b00}. The low 12 bits of the root are ignored.
- R3: If the first entry is valid (bit 0 set), the second read address is {entry1[31:12], vaddr[21:12], 2'b00}.
- R4: If the first entry has bit 0 clear, done is raised with fault=1 and no second read is issued.
- R5: If the second entry is valid, paddr = {entry2[31:12], vaddr[11:0]} and fault=0.
- R6: If the second entry has bit 0 clear, the result is a fault and the cache is not filled. The same request, sent again after the entry is made valid, walks again and succeeds.
- R7: A request whose VPN hits in the cache finishes with fault=0, the cached frame number, and zero memory reads.
- R8: The cache line index is VPN[3:0] and the tag is VPN[19:4]. A fill evicts only the line at its own index, so two VPNs with the same index displace each other.
- R9: Flush clears every line. If flush arrives in the same cycle as a fill, the flush wins and the line stays empty.
- R10: req_ready is high only when the block is idle. It drops in the cycle after a request is accepted.
- R11: done lasts exactly one cycle. fault and paddr change only together with done.
- R12: Under reset, req_ready=1, done=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Base address of the first-level table (4 KB aligned) |
| flush | input | 1 | Invalidate all translation cache lines |
| mem_req_valid | output | 1 | One-cycle word read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Last result was a page fault |
| paddr | output | 32 | Last translated physical address |

## Verification
Two functions can land in the same cycle: a flush and the cache fill made by a walk that completes. The bench memory model raises flush in exactly the cycle it returns the final valid entry of a walk.

That walk must still report the correct address. The same virtual address is then requested again, and the bench counts memory reads on that request. Seeing two reads instead of zero shows that the flush won over the fill.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int XLEN  = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = 2 * IDX_W;
    localparam int PPN_W = XLEN - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WAIT1  = 2'd2,
        ST_WAIT2  = 2'd3
    } walk_state_e;

    // Entry address: table base (frame aligned) plus four bytes per index.
    function automatic logic [XLEN-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return {base, {OFF_W{1'b0}}} + (XLEN'(idx) << 2);
    endfunction
endpackage

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int LINES = 16,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush
);
    localparam int IX_W  = $clog2(LINES);
    localparam int TAG_W = VPN_W - IX_W;

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0][PPN_W-1:0] ppn;
    } tc_s;

    tc_s tc_d, tc_q;

    logic [IX_W-1:0] lk_ix, fill_ix;
    assign lk_ix   = lk_vpn[IX_W-1:0];
    assign fill_ix = fill_vpn[IX_W-1:0];

    always_comb begin
        tc_d = tc_q;
        if (flush) begin
            tc_d.vld = '0;
        end else if (fill_en) begin
            tc_d.vld[fill_ix] = 1'b1;
            tc_d.tag[fill_ix] = fill_vpn[VPN_W-1:IX_W];
            tc_d.ppn[fill_ix] = fill_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= '0;
        else        tc_q <= tc_d;
    end

    assign lk_hit = tc_q.vld[lk_ix] && (tc_q.tag[lk_ix] == lk_vpn[VPN_W-1:IX_W]);
    assign lk_ppn = tc_q.ppn[lk_ix];

    // R9: a flush leaves no line valid, whatever else happened that cycle.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tc_q.vld == '0));

    // R8: a fill without flush makes the same VPN hit next cycle.
    a_r8_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && lk_vpn == fill_vpn) ##1 (lk_vpn == $past(fill_vpn)) |-> lk_hit);
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [XLEN-1:0]  req_vaddr,
    input  logic [XLEN-1:0]  req_root,
    output logic [VPN_W-1:0] tc_vpn,
    input  logic             tc_hit,
    input  logic [PPN_W-1:0] tc_ppn,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    output logic             mem_req_valid,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [XLEN-1:0]  paddr
);
    typedef struct packed {
        walk_state_e      st;
        logic [XLEN-1:0]  va;
        logic [PPN_W-1:0] root;
        logic             mem_v;
        logic [XLEN-1:0]  mem_a;
        logic             done;
        logic             fault;
        logic [XLEN-1:0]  pa;
    } walk_s;

    walk_s w_d, w_q;

    logic             rsp_ok;
    logic [PPN_W-1:0] rsp_ppn;
    assign rsp_ok  = mem_rsp_data[0];
    assign rsp_ppn = mem_rsp_data[XLEN-1:OFF_W];

    logic unused_bits;
    assign unused_bits = ^{req_root[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        w_d.mem_v = 1'b0;
        fill_en  = 1'b0;
        fill_ppn = rsp_ppn;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.va   = req_vaddr;
                    w_d.root = req_root[XLEN-1:OFF_W];
                    w_d.st   = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (tc_hit) begin
                    w_d.done  = 1'b1;
                    w_d.fault = 1'b0;
                    w_d.pa    = {tc_ppn, w_q.va[OFF_W-1:0]};
                    w_d.st    = ST_IDLE;
                end else begin
                    w_d.mem_v = 1'b1;
                    w_d.mem_a = entry_addr(w_q.root, w_q.va[XLEN-1 -: IDX_W]);
                    w_d.st    = ST_WAIT1;
                end
            end
            ST_WAIT1: begin
                if (mem_rsp_valid) begin
                    if (!rsp_ok) begin
                        w_d.done  = 1'b1;
                        w_d.fault = 1'b1;
                        w_d.st    = ST_IDLE;
                    end else begin
                        w_d.mem_v = 1'b1;
                        w_d.mem_a = entry_addr(rsp_ppn, w_q.va[OFF_W +: IDX_W]);
                        w_d.st    = ST_WAIT2;
                    end
                end
            end
            ST_WAIT2: begin
                if (mem_rsp_valid) begin
                    w_d.done = 1'b1;
                    w_d.st   = ST_IDLE;
                    if (!rsp_ok) begin
                        w_d.fault = 1'b1;
                    end else begin
                        w_d.fault = 1'b0;
                        w_d.pa    = {rsp_ppn, w_q.va[OFF_W-1:0]};
                        fill_en   = 1'b1;
                    end
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready     = (w_q.st == ST_IDLE);
    assign tc_vpn        = w_q.va[XLEN-1:OFF_W];
    assign fill_vpn      = w_q.va[XLEN-1:OFF_W];
    assign mem_req_valid = w_q.mem_v;
    assign mem_req_addr  = w_q.mem_a;
    assign done          = w_q.done;
    assign fault         = w_q.fault;
    assign paddr         = w_q.pa;

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_LOOKUP && tc_hit) |=> (done && !fault && !mem_req_valid));

    a_r4_empty_top_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_WAIT1 && mem_rsp_valid && !mem_rsp_data[0])
        |=> (done && fault && !mem_req_valid));

    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_LOOKUP && !tc_hit)
        |=> (mem_req_valid && mem_req_addr == {w_q.root, w_q.va[31:22], 2'b00}));

    a_r3_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_WAIT1 && mem_rsp_valid && mem_rsp_data[0])
        |=> (mem_req_valid &&
             mem_req_addr == {$past(mem_rsp_data[31:12]), w_q.va[21:12], 2'b00}));

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (paddr[OFF_W-1:0] == w_q.va[OFF_W-1:0]));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(paddr) && $stable(fault)));
endmodule

// File: rtl/pagewalk_xlate.sv
module pagewalk_xlate
    import ptw_pkg::*;
#(
    parameter int TC_LINES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_root,
    input  logic        flush,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic        fault,
    output logic [31:0] paddr
);
    logic [VPN_W-1:0] tc_vpn, fill_vpn;
    logic [PPN_W-1:0] tc_ppn, fill_ppn;
    logic             tc_hit, fill_en;

    walk_fsm u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .tc_vpn        (tc_vpn),
        .tc_hit        (tc_hit),
        .tc_ppn        (tc_ppn),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_ppn      (fill_ppn),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr)
    );

    xlate_cache #(
        .LINES (TC_LINES),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (tc_vpn),
        .lk_hit   (tc_hit),
        .lk_ppn   (tc_ppn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .flush    (flush)
    );

    // R12: idle and quiet while reset is held.
    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (req_ready && !done && !mem_req_valid));
endmodule

// File: tb/pagewalk_xlate_tb_top.sv
`timescale 1ns/1ps
module pagewalk_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        flush_drv = 1'b0;
    logic        flush_mem = 1'b0;
    logic        flush;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [31:0] paddr;

    assign flush = flush_drv | flush_mem;

    always #4 clk = ~clk;

    pagewalk_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .flush(flush),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .paddr(paddr)
    );

    int n_checks = 0;
    int n_err = 0;
    int mem_reads = 0;
    int n_issued = 0;
    int n_done = 0;
    int hold_viol = 0;
    logic [31:0] flush_at = 32'hFFFF_FFFF;
    logic [31:0] pt_mem [logic [31:0]];

    typedef struct {
        bit          f;
        logic [31:0] pa;
        int          rd;
        int          start;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (pt_mem.exists(a)) return pt_mem[a];
        return 32'h0;
    endfunction

    // Memory model: read seen at a negedge, answered one cycle later.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            flush_mem     = 1'b0;
            if (mem_req_valid) begin
                logic [31:0] a;
                a = mem_req_addr;
                mem_reads++;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd_mem(a);
                if (a == flush_at) flush_mem = 1'b1;
            end
        end
    end

    // Monitor: compare each result with the scoreboard head.
    initial begin
        logic [31:0] last_pa;
        logic        last_f;
        bit          have;
        have = 1'b0;
        last_pa = '0;
        last_f = 1'b0;
        forever begin
            @(negedge clk);
            if (done) begin
                exp_t e;
                e = sb.pop_front();
                chk(fault == e.f, e.req, "fault", {31'b0, fault}, {31'b0, e.f});
                if (!e.f) chk(paddr == e.pa, e.req, "paddr", paddr, e.pa);
                chk(mem_reads - e.start == e.rd, e.req, "memory reads",
                    mem_reads - e.start, e.rd);
                last_pa = paddr;
                last_f  = fault;
                have    = 1'b1;
                n_done++;
            end else if (have && (paddr !== last_pa || fault !== last_f)) begin
                hold_viol++;
            end
        end
    end

    task automatic xlate(input logic [31:0] va, input logic [31:0] root, input bit f,
                         input logic [31:0] pa, input int rd, input string req);
        exp_t e;
        e.f = f; e.pa = pa; e.rd = rd; e.start = mem_reads; e.req = req;
        sb.push_back(e);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready after accept", {31'b0, req_ready}, 32'h0);
        while (n_done < n_issued) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done pulse width", {31'b0, done}, 32'h0);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_drv = 1'b1;
        @(negedge clk);
        flush_drv = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    localparam logic [31:0] ROOT1 = 32'h0001_0000;
    localparam logic [31:0] ROOT2 = 32'h0003_0000;
    localparam logic [31:0] VA_A  = 32'h0040_3ABC;
    localparam logic [31:0] VA_B  = 32'h0041_3000;  // same line index as VA_A
    localparam logic [31:0] VA_C  = 32'h0040_5000;
    localparam logic [31:0] VA_E  = 32'h0080_0123;  // top index 2 left empty

    initial begin
        pt_mem[32'h0001_0004] = 32'h0002_0001;
        pt_mem[32'h0002_000C] = 32'h0ABC_D001;
        pt_mem[32'h0002_004C] = 32'h0555_5001;
        pt_mem[32'h0003_0004] = 32'h0004_0001;
        pt_mem[32'h0004_000C] = 32'h0999_9001;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R12", "ready in reset", {31'b0, req_ready}, 32'h1);
        chk(done == 1'b0, "R12", "done in reset", {31'b0, done}, 32'h0);
        chk(mem_req_valid == 1'b0, "R12", "mem req in reset", {31'b0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        xlate(VA_A, ROOT1, 1'b0, 32'h0ABC_DABC, 2, "R5 R1 R2 R3 full walk");
        xlate(VA_A, ROOT1, 1'b0, 32'h0ABC_DABC, 0, "R7 cache hit");
        xlate(VA_E, ROOT1, 1'b1, 32'h0, 1, "R4 empty top entry");
        xlate(VA_C, ROOT1, 1'b1, 32'h0, 2, "R6 empty leaf entry");
        pt_mem[32'h0002_0014] = 32'h0777_7001;
        xlate(VA_C, ROOT1, 1'b0, 32'h0777_7000, 2, "R6 retry after repair");
        xlate(VA_B, ROOT1, 1'b0, 32'h0555_5000, 2, "R8 conflicting vpn walk");
        xlate(VA_A, ROOT1, 1'b0, 32'h0ABC_DABC, 2, "R8 evicted line walks");
        xlate(VA_C, ROOT1, 1'b0, 32'h0777_7000, 0, "R8 other line kept");
        pulse_flush();
        xlate(VA_A, ROOT1, 1'b0, 32'h0ABC_DABC, 2, "R9 walk after flush");
        flush_at = 32'h0002_004C;
        xlate(VA_B, ROOT1, 1'b0, 32'h0555_5000, 2, "R9 flush with fill result");
        flush_at = 32'hFFFF_FFFF;
        xlate(VA_B, ROOT1, 1'b0, 32'h0555_5000, 2, "R9 flush beat fill");
        xlate(VA_B, ROOT1, 1'b0, 32'h0555_5000, 0, "R9 refill hits");
        pulse_flush();
        xlate(VA_A, ROOT2, 1'b0, 32'h0999_9ABC, 2, "R2 second root");

        chk(hold_viol == 0, "R11", "result held between pulses", hold_viol, 0);
        chk(sb.size() == 0, "R11", "results outstanding", sb.size(), 0);
        summary();
        $finish;
    end
endmodule